// File: doc/BRIEF.md
# Multidrop Address-Wakeup Receive Filter

This block sits between a UART character deserializer and the host-facing receive queue. It adds 9-bit multidrop handling. Each incoming character carries an address/data flag in the bit position that ordinary framing uses for parity. While the receiver is off, the filter keeps watching the line. It queues only address characters, and the ready indication they raise lets software compare the address and switch the receiver on. While the receiver is on, every character is queued, and its flag goes into the status entry.

The queue is a paired data/status FIFO, eight entries deep by default. Status bit 5 holds the address/data flag in multidrop mode, or a parity error in normal mode. Bit 6 holds the framing error and bit 7 holds the break bit. Framing, break and overrun detection run the same way whether or not the receiver is on. Host software turns the receiver on and off with single-cycle strobes. A disable waits until the deserializer is between characters.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset the queue is empty (`ready`=0), the receiver is off (`rx_on`=0), and `ovr`, `ferr_seen` and `brk_seen` are 0.
- R2: With `md_mode`=1 and the receiver off, a character with `ch_flag`=1 is queued and raises `ready` one cycle later. A character with `ch_flag`=0 is discarded and leaves the queue unchanged.
- R3: For a queued character, `out_data` shows its 8 data bits. In multidrop mode, `out_status[5]` shows its `ch_flag`. `out_status[7]` is its break bit, `out_status[6]` is its framing bit, and bits 4..0 are 0.
- R4: With `md_mode`=1 and the receiver on, every character is queued, whatever its flag, with the flag in `out_status[5]`.
- R5: With `md_mode`=0, no parity check is skipped. `out_status[5]` is 1 when the XOR of the 8 data bits and `ch_flag` is 1 (even parity expected). With the receiver off in this mode, no character is queued.
- R6: Any valid character with its framing bit set makes `ferr_seen` go to 1, and any valid character with its break bit set makes `brk_seen` go to 1. This holds even when the character is discarded. Both flags stay at 1 until `clr_err`.
- R7: A character that should be queued while the queue holds DEPTH entries and no pop occurs is dropped, and `ovr` is set. `ovr` stays at 1 until `clr_err`.
- R8: `rx_en_stb` turns the receiver on from the next cycle. `rx_dis_stb` turns it off in the first cycle with `rx_busy`=0. A character valid in the same cycle as a strobe is filtered under the prior state. When both strobes occur together, or while a disable is pending, the disable wins.
- R9: The queue is first-in first-out. `pop` removes the head when `ready`=1 and has no effect on an empty queue. The queue never holds more than DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| md_mode | input | 1 | 1 selects multidrop address/data handling |
| rx_en_stb | input | 1 | One-cycle receiver enable strobe |
| rx_dis_stb | input | 1 | One-cycle receiver disable strobe |
| rx_busy | input | 1 | Deserializer is in the middle of a character |
| ch_valid | input | 1 | A completed character is presented |
| ch_data | input | 8 | Character data bits |
| ch_flag | input | 1 | Ninth bit: address/data flag or parity bit |
| ch_ferr | input | 1 | Framing error of the character |
| ch_brk | input | 1 | Break detected on the character |
| pop | input | 1 | Remove the queue head |
| clr_err | input | 1 | Clear the sticky overrun, framing and break flags |
| out_data | output | 8 | Data bits of the queue head |
| out_status | output | 8 | Status of the queue head (bit 7 break, bit 6 framing, bit 5 flag or parity error) |
| ready | output | 1 | Queue not empty |
| rx_on | output | 1 | Receiver currently enabled |
| ovr | output | 1 | Sticky overrun flag |
| ferr_seen | output | 1 | Sticky framing-error flag |
| brk_seen | output | 1 | Sticky break flag |

## Verification
Some rules are checked on every cycle. A data character that arrives while the receiver is off in multidrop mode must leave the occupancy unchanged. The sticky flags must hold until cleared. The receiver must not turn off while a character is in progress. Occupancy must never exceed the depth. Other behaviour only the directed scenarios can show. These are the contents and bit positions of the status entry, the parity result in normal mode, FIFO ordering across an overrun, and the state a character sees when it arrives in the same cycle as a strobe.

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       md_mode,
  input  logic       rx_en_stb,
  input  logic       rx_dis_stb,
  input  logic       rx_busy,
  input  logic       ch_valid,
  input  logic [7:0] ch_data,
  input  logic       ch_flag,
  input  logic       ch_ferr,
  input  logic       ch_brk,
  input  logic       pop,
  input  logic       clr_err,
  output logic [7:0] out_data,
  output logic [7:0] out_status,
  output logic       ready,
  output logic       rx_on,
  output logic       ovr,
  output logic       ferr_seen,
  output logic       brk_seen
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]  dmem [DEPTH];
  logic [2:0]  smem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          rx_en, dis_pend;

  wire slot5   = md_mode ? ch_flag : ^{ch_data, ch_flag};
  wire load    = ch_valid && (rx_en || (md_mode && ch_flag));
  wire full    = (cnt == (AW+1)'(DEPTH));
  wire do_pop  = pop && (cnt != '0);
  wire do_push = load && (!full || do_pop);

  assign ready      = (cnt != '0);
  assign rx_on      = rx_en;
  assign out_data   = dmem[rd_ptr];
  assign out_status = {smem[rd_ptr], 5'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      dis_pend <= 1'b0;
    end else if (rx_dis_stb || dis_pend) begin
      if (!rx_busy) begin
        rx_en    <= 1'b0;
        dis_pend <= 1'b0;
      end else begin
        dis_pend <= 1'b1;
      end
    end else if (rx_en_stb) begin
      rx_en <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      dmem[wr_ptr] <= ch_data;
      smem[wr_ptr] <= {ch_brk, ch_ferr, slot5};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr       <= 1'b0;
      ferr_seen <= 1'b0;
      brk_seen  <= 1'b0;
    end else begin
      if (clr_err) begin
        ovr       <= 1'b0;
        ferr_seen <= 1'b0;
        brk_seen  <= 1'b0;
      end
      if (load && full && !do_pop) ovr <= 1'b1;
      if (ch_valid && ch_ferr)     ferr_seen <= 1'b1;
      if (ch_valid && ch_brk)      brk_seen <= 1'b1;
    end
  end
endmodule

module mdrop_rx_filter_chk #(
  parameter int DEPTH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic md_mode,
  input logic rx_busy,
  input logic ch_valid,
  input logic ch_flag,
  input logic ch_ferr,
  input logic pop,
  input logic clr_err,
  input logic rx_on,
  input logic ovr,
  input logic ferr_seen,
  input logic ready,
  input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1):0] cnt
);
  assert_drop_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (md_mode && !rx_on && ch_valid && !ch_flag && !pop) |=> (cnt == $past(cnt)));

  assert_ferr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && ch_ferr) |=> ferr_seen);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_err) |=> ovr);

  assert_no_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && rx_on) |=> rx_on);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($bits(cnt))'(DEPTH));

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && pop && !ch_valid) |=> !ready);
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/mdrop_rx_filter_test.sv
module mdrop_rx_filter_test;
  logic clk = 0, rst_n = 0;
  logic md_mode = 0, rx_en_stb = 0, rx_dis_stb = 0, rx_busy = 0;
  logic ch_valid = 0, ch_flag = 0, ch_ferr = 0, ch_brk = 0, pop = 0, clr_err = 0;
  logic [7:0] ch_data = 0;
  logic [7:0] out_data, out_status;
  logic ready, rx_on, ovr, ferr_seen, brk_seen;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mdrop_rx_filter uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic f, input logic fe = 0, input logic bk = 0);
    @(negedge clk);
    ch_valid = 1; ch_data = d; ch_flag = f; ch_ferr = fe; ch_brk = bk;
    @(negedge clk);
    ch_valid = 0; ch_ferr = 0; ch_brk = 0;
  endtask

  task automatic pulse_en();
    @(negedge clk); rx_en_stb = 1; @(negedge clk); rx_en_stb = 0;
  endtask

  task automatic pulse_dis();
    @(negedge clk); rx_dis_stb = 1; @(negedge clk); rx_dis_stb = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_err = 1; @(negedge clk); clr_err = 0;
  endtask

  task automatic pop_expect(string tag, int d, int s);
    chk({tag, " ready"}, ready, 1);
    chk({tag, " data"}, out_data, d);
    chk({tag, " status"}, out_status, s);
    pop = 1; @(negedge clk); pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 ready", ready, 0);
    chk("R1 rx_on", rx_on, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 ferr", ferr_seen, 0);
    chk("R1 brk", brk_seen, 0);
  endtask

  task automatic t_wakeup();
    md_mode = 1;
    send(8'h33, 0);
    chk("R2 data dropped", ready, 0);
    send(8'h5A, 1);
    chk("R2 address queued", ready, 1);
    pop_expect("R3 address", 8'h5A, 8'h20);
    chk("R9 empty after pop", ready, 0);
    @(negedge clk); pop = 1; @(negedge clk); pop = 0;
    chk("R9 pop empty", ready, 0);
  endtask

  task automatic t_enabled();
    pulse_en();
    chk("R8 enabled", rx_on, 1);
    send(8'h11, 0);
    send(8'h22, 1);
    send(8'h44, 0, 1, 0);
    pop_expect("R4 data char", 8'h11, 8'h00);
    pop_expect("R4 addr char", 8'h22, 8'h20);
    pop_expect("R3 framing bit", 8'h44, 8'h40);
    pulse_clr();
  endtask

  task automatic t_normal();
    md_mode = 0;
    send(8'h03, 0);
    send(8'h01, 0);
    send(8'h01, 1);
    pop_expect("R5 good parity", 8'h03, 8'h00);
    pop_expect("R5 bad parity", 8'h01, 8'h20);
    pop_expect("R5 good parity flag1", 8'h01, 8'h00);
    pulse_dis();
    chk("R8 disabled", rx_on, 0);
    send(8'h77, 1);
    chk("R5 off normal mode", ready, 0);
  endtask

  task automatic t_errors();
    md_mode = 1;
    send(8'h10, 0, 1, 1);
    chk("R6 ferr on dropped", ferr_seen, 1);
    chk("R6 brk on dropped", brk_seen, 1);
    chk("R6 not queued", ready, 0);
    @(negedge clk);
    chk("R6 ferr sticky", ferr_seen, 1);
    pulse_clr();
    chk("R6 ferr cleared", ferr_seen, 0);
    chk("R6 brk cleared", brk_seen, 0);
  endtask

  task automatic t_overrun();
    pulse_en();
    for (int i = 0; i < 9; i++) send(8'(8'hA0 + i), 0);
    chk("R7 ovr set", ovr, 1);
    @(negedge clk); @(negedge clk);
    chk("R7 ovr sticky", ovr, 1);
    for (int i = 0; i < 8; i++) pop_expect("R7 kept order", 8'hA0 + i, 8'h00);
    chk("R7 ninth dropped", ready, 0);
    pulse_clr();
    chk("R7 ovr cleared", ovr, 0);
  endtask

  task automatic t_disable_timing();
    @(negedge clk); rx_busy = 1; rx_dis_stb = 1;
    @(negedge clk); rx_dis_stb = 0;
    chk("R8 deferred while busy", rx_on, 1);
    send(8'h66, 0);
    chk("R8 char during pending", ready, 1);
    rx_busy = 0;
    @(negedge clk);
    chk("R8 off after busy", rx_on, 0);
    pop_expect("R8 pending char", 8'h66, 8'h00);
    pulse_en();
    @(negedge clk);
    rx_dis_stb = 1; ch_valid = 1; ch_data = 8'h99; ch_flag = 0;
    @(negedge clk);
    rx_dis_stb = 0; ch_valid = 0;
    chk("R8 same-cycle char kept", ready, 1);
    chk("R8 same-cycle off", rx_on, 0);
    pop_expect("R8 same-cycle data", 8'h99, 8'h00);
    @(negedge clk); rx_en_stb = 1; rx_dis_stb = 1;
    @(negedge clk); rx_en_stb = 0; rx_dis_stb = 0;
    chk("R8 disable wins", rx_on, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wakeup();
    t_enabled();
    t_normal();
    t_errors();
    t_overrun();
    t_disable_timing();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule